// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing controller of a serial EEPROM slave on a two-wire bus. It oversamples the clock (SCL) and data (SDA) lines with the system clock and recognises start and stop conditions. It takes in a device header byte and checks it against three strap pins. It loads an 11-bit word pointer and then carries out byte writes, page writes, current-pointer reads, random reads and sequential reads. The engine never drives SDA high. It only raises an active-high pull-down enable (`sda_pull`), which it uses for acknowledges and for the zero bits of read data.

The memory array and its write timing live in a separate block. This engine presents a word address, write data and a one-cycle write strobe to that block. It also issues a one-cycle fetch strobe and samples the read data, which the memory block returns combinationally from `mem_addr`.

The control is a single state machine. Its states are `ST_IDLE`, `ST_DEV`, `ST_DEV_ACK`, `ST_WADDR`, `ST_WADDR_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA` and `ST_RACK`. A start condition moves any state to `ST_DEV`, and a stop condition moves any state to `ST_IDLE`. The other transitions all happen on a synchronised SCL falling edge:

- `ST_DEV` goes to `ST_DEV_ACK` when the header matches, or to `ST_IDLE` when it does not.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read header, or to `ST_WADDR` for a write header.
- `ST_WADDR` goes to `ST_WADDR_ACK`, and `ST_WADDR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate, one pass per data byte.
- `ST_RDATA` goes to `ST_RACK` after eight bits have been sent.
- `ST_RACK` goes back to `ST_RDATA` when the master acknowledged, or to `ST_IDLE` when it did not.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) in any state sends the engine to header reception. A stop condition (SDA rising while SCL is high) sends it to idle. After either, the engine answers only a fresh start followed by a header.
- R2: The header arrives MSB first. Bit 7 must be 1. Bits 6, 5 and 4 must equal `strap[2]`, the inverse of `strap[1]`, and `strap[0]`. On a match, `sda_pull` is high through the ninth clock. On a mismatch, `sda_pull` stays low until the next start.
- R3: Bits are sampled on the synchronised SCL rising edge. `sda_pull` changes only while the synchronised SCL is low, so it never produces a start or stop on the bus.
- R4: In a write header (bit 0 = 0), bits 3:1 become word address bits 10:8. The next byte supplies bits 7:0 and is acknowledged.
- R5: Each data byte after the word address is acknowledged. Each one produces exactly one `mem_wr` pulse, carrying that byte on `mem_wdata` and the current pointer on `mem_addr`.
- R6: After each written byte, the pointer's low 4 bits advance and wrap inside the 16-byte page, and bits 10:4 do not change.
- R7: After an acknowledged read header (bit 0 = 1), bytes are sent MSB first from the pointer. Each fetch pulses `mem_rd` once and advances the pointer.
- R8: A read header's bits 3:1 are ignored. A read that follows a repeated start, or one with no preceding word address, continues from the byte after the last one accessed.
- R9: In a read, a master acknowledge (SDA low on the ninth clock) sends the next byte. The pointer wraps from 0x7FF to 0x000.
- R10: After a master non-acknowledge, the engine releases SDA, fetches nothing more, and ignores further clocks until the next start.
- R11: A start or stop in the middle of a byte produces no `mem_wr`. If it falls within the word address byte, the pointer is left unchanged.
- R12: While reset is asserted and right after it, `sda_pull`, `mem_wr` and `mem_rd` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired level) |
| strap | input | 3 | Device select strap pins |
| mem_rdata | input | 8 | Read data for `mem_addr`, combinational from the memory block |
| sda_pull | output | 1 | Active-high pull-down enable for SDA |
| mem_addr | output | 11 | Current word pointer |
| mem_wdata | output | 8 | Byte to write, valid with `mem_wr` |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle fetch strobe; `mem_rdata` is taken in the same cycle |

## Verification
The assertions that tie `sda_pull` changes to SCL-low periods assume a legal bus master. Such a master changes SDA only while SCL is low, except to form start and stop conditions. It never makes a start or stop while the slave is pulling SDA low. It also holds each SCL phase for at least five system clocks, so the synchroniser delay ends before the next phase begins. The bench master keeps every SCL phase at ten system clocks. It changes its own SDA only a few clocks into the low phase, after the engine has reacted to the falling edge. It issues starts and stops only while the slave is not pulling SDA. Strap values change only while the bus is idle.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    localparam int EEP_BLK_W  = 3;
    localparam int EEP_BYTE_W = 8;
    localparam int EEP_ADDR_W = EEP_BLK_W + EEP_BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eep_state_t;
endpackage

// File: rtl/eep_line_sync.sv
`timescale 1ns/1ps
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_addr_ctr.sv
`timescale 1ns/1ps
module eep_addr_ctr #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_rd,
    input  logic              inc_wr,
    output logic [ADDR_W-1:0] addr
);
    localparam int ROW_W = ADDR_W - PAGE_BITS;

    logic [ROW_W-1:0]     row;
    logic [PAGE_BITS-1:0] col;

    assign row = addr[ADDR_W-1:PAGE_BITS];
    assign col = addr[PAGE_BITS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc_rd) begin
            addr <= addr + 1'b1;
        end else if (inc_wr) begin
            addr <= {row, col + 1'b1};
        end
    end

    // R9: a fetch from the top of the array moves the pointer to zero
    assert_read_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_rd && !load && (&addr)) |=> (addr == '0));

    // R6: a write advance never leaves the page row
    assert_page_row_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_wr && !load && !inc_rd) |=> (row == $past(row)));
endmodule

// File: rtl/twowire_eeprom_slave.sv
`timescale 1ns/1ps
module twowire_eeprom_slave
    import eep_pkg::*;
#(
    parameter int PAGE_BITS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [2:0]            strap,
    input  logic [EEP_BYTE_W-1:0] mem_rdata,
    output logic                  sda_pull,
    output logic [EEP_ADDR_W-1:0] mem_addr,
    output logic [EEP_BYTE_W-1:0] mem_wdata,
    output logic                  mem_wr,
    output logic                  mem_rd
);
    localparam int BIT_W = $clog2(EEP_BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(EEP_BYTE_W - 1);

    eep_state_t state, nstate;

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [BIT_W-1:0]      bitcnt;
    logic                  full;
    logic [EEP_BYTE_W-1:0] shreg;
    logic [EEP_BLK_W-1:0]  blk;
    logic                  rw;
    logic                  mack;
    logic                  dev_match;
    logic                  wr_stb, rd_stb, ld_addr;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // header: 1, select bits (middle one inverted), block bits, direction
    assign dev_match = shreg[7] && (shreg[6] == strap[2]) &&
                       (shreg[5] == ~strap[1]) && (shreg[4] == strap[0]);

    assign wr_stb  = (state == ST_WDATA) && scl_fall && full;
    assign ld_addr = (state == ST_WADDR) && scl_fall && full;
    assign rd_stb  = scl_fall && (((state == ST_DEV_ACK) && rw) ||
                                  ((state == ST_RACK) && mack));

    eep_addr_ctr #(.ADDR_W(EEP_ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_addr),
        .load_val ({blk, shreg}),
        .inc_rd   (rd_stb),
        .inc_wr   (wr_stb),
        .addr     (mem_addr)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        if (start_evt) begin
            nstate = ST_DEV;
        end else if (stop_evt) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nstate = ST_IDLE;
                ST_DEV:       if (scl_fall && full) nstate = dev_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) nstate = rw ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (scl_fall && full) nstate = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) nstate = ST_WDATA;
                ST_WDATA:     if (scl_fall && full) nstate = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nstate = ST_WDATA;
                ST_RDATA:     if (scl_fall && (bitcnt == LAST_BIT)) nstate = ST_RACK;
                ST_RACK:      if (scl_fall) nstate = mack ? ST_RDATA : ST_IDLE;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // shift, bit count and header capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            full   <= 1'b0;
            shreg  <= '0;
            blk    <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
        end else if (start_evt) begin
            bitcnt <= '0;
            full   <= 1'b0;
        end else if (rd_stb) begin
            shreg  <= mem_rdata;
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[EEP_BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) full <= 1'b1;
                    end else if (scl_fall && full) begin
                        full <= 1'b0;
                        if ((state == ST_DEV) && dev_match) begin
                            rw <= shreg[0];
                            if (!shreg[0]) blk <= shreg[3:1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        shreg  <= {shreg[EEP_BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_s;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull  = 1'b0;
        mem_wdata = shreg;
        mem_wr    = wr_stb;
        mem_rd    = rd_stb;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_RDATA:                               sda_pull = ~shreg[EEP_BYTE_W-1];
            default:                                sda_pull = 1'b0;
        endcase
    end

    // R3: the pull-down enable only moves while SCL is low
    assert_pull_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);

    // R2: a rejected header leaves the line released
    assert_mismatch_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && scl_fall && full && !dev_match && !start_evt) |=> !sda_pull);

    // R11: no write strobe while SCL is high (a byte is only committed after its eighth bit)
    assert_write_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!scl_s && !mem_rd));
endmodule

// File: tb/test_twowire_eeprom_slave.sv
`timescale 1ns/1ps
module test_twowire_eeprom_slave;
    localparam int HP    = 10;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_pull;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_wr, mem_rd;
    wire         sda_line;

    logic [7:0] mem       [DEPTH];
    logic [7:0] model_mem [DEPTH];
    int  model_ptr = 0;
    int  checks = 0, fails = 0, wr_count = 0, rd_count = 0, stray = 0;
    bit  slot = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = m_sda & ~sda_pull;
    assign mem_rdata = mem[mem_addr];

    twowire_eeprom_slave i_twowire_eeprom_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .strap     (strap),
        .mem_rdata (mem_rdata),
        .sda_pull  (sda_pull),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_wr    (mem_wr),
        .mem_rd    (mem_rd)
    );

    // memory side model driven only by the port strobes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 7 + 3);
        end else begin
            if (mem_wr) begin
                mem[mem_addr] <= mem_wdata;
                wr_count++;
            end
            if (mem_rd) rd_count++;
        end
    end

    // every-clock comparison: the slave may only pull in slots the model allows (R2, R3)
    always @(negedge clk) begin
        if (rst_n && sda_pull && !slot) begin
            fails++;
            if (stray < 4) $display("FAIL R3 pull outside an allowed slot act=1 exp=0 t=%0t", $time);
            stray++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic logic [7:0] hdr(input logic [2:0] s, input logic [2:0] b, input logic r);
        return {1'b1, s[2], ~s[1], s[0], b, r};
    endfunction

    task automatic b_start();
        if (scl) begin
            m_sda = 1'b0; tick(HP); scl = 1'b0;
        end else begin
            tick(5); slot = 1'b0; m_sda = 1'b1; tick(HP - 5);
            scl = 1'b1; tick(HP); m_sda = 1'b0; tick(HP); scl = 1'b0;
        end
    endtask

    task automatic b_stop();
        tick(5); slot = 1'b0; m_sda = 1'b0; tick(HP - 5);
        scl = 1'b1; tick(HP); m_sda = 1'b1; tick(HP);
    endtask

    task automatic send_bit(input logic b);
        tick(5); slot = 1'b0; m_sda = b; tick(HP - 5);
        scl = 1'b1; tick(HP); scl = 1'b0;
    endtask

    task automatic recv_bit(input bit allow, output logic v);
        slot = allow; tick(5); m_sda = 1'b1; tick(HP - 5);
        scl = 1'b1; tick(HP / 2); v = sda_line; tick(HP / 2); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit allow, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(allow, a);
        ack = !a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(1'b1, v);
            d[i] = v;
        end
        send_bit(!give_ack);
    endtask

    task automatic set_ptr(input logic [2:0] s, input int addr);
        bit a;
        b_start();
        send_byte(hdr(s, addr[10:8], 1'b0), 1'b1, a);
        chk(a, "R2 header ack", a, 1);
        send_byte(addr[7:0], 1'b1, a);
        chk(a, "R4 word address ack", a, 1);
        model_ptr = addr;
    endtask

    task automatic read_seq(input logic [2:0] s, input logic [2:0] b, input int n, input string req);
        bit a;
        logic [7:0] d;
        b_start();
        send_byte(hdr(s, b, 1'b1), 1'b1, a);
        chk(a, "R7 read header ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == model_mem[model_ptr], req, d, model_mem[model_ptr]);
            model_ptr = (model_ptr + 1) % DEPTH;
        end
    endtask

    task automatic write_bytes(input logic [2:0] s, input int addr, input int n, input logic [7:0] base);
        bit a;
        int wr0;
        wr0 = wr_count;
        set_ptr(s, addr);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = base + 8'(i * 17);
            send_byte(d, 1'b1, a);
            chk(a, "R5 data ack", a, 1);
            model_mem[(addr & 32'h7F0) | ((addr + i) & 32'hF)] = d;
        end
        b_stop();
        model_ptr = (addr & 32'h7F0) | ((addr + n) & 32'hF);
        chk(wr_count == wr0 + n, "R5 one strobe per byte", wr_count - wr0, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        bit a;
        logic v;
        logic [7:0] d;
        int wr0, rd0, keep;

        for (int i = 0; i < DEPTH; i++) model_mem[i] = 8'(i * 7 + 3);

        // R12: reset state
        tick(5);
        chk(sda_pull == 1'b0, "R12 pull in reset", sda_pull, 0);
        chk(!mem_wr && !mem_rd, "R12 strobes in reset", {mem_wr, mem_rd}, 0);
        rst_n = 1'b1;
        tick(5);
        chk(sda_pull == 1'b0, "R12 pull after reset", sda_pull, 0);

        // R4 R5: byte write to 0x5A3, then random read back (R7)
        write_bytes(3'b101, 32'h5A3, 1, 8'h3C);
        chk(mem[11'h5A3] == 8'h3C, "R5 byte landed", mem[11'h5A3], 8'h3C);
        set_ptr(3'b101, 32'h5A3);
        rd0 = rd_count;
        read_seq(3'b101, 3'b000, 1, "R7 random read data");
        recv_bit(1'b0, v);
        chk(v == 1'b1, "R10 line released after nack", v, 1);
        chk(rd_count == rd0 + 1, "R10 no fetch after nack", rd_count - rd0, 1);
        b_stop();

        // R6: page write of four bytes starting at 0x27E wraps inside its page
        write_bytes(3'b101, 32'h27E, 4, 8'h11);
        chk(mem[11'h270] == 8'h33, "R6 page wrap target", mem[11'h270], 8'h33);
        chk(mem[11'h280] == 8'(32'h280 * 7 + 3), "R6 next page untouched", mem[11'h280], 8'(32'h280 * 7 + 3));
        set_ptr(3'b101, 32'h270);
        read_seq(3'b101, 3'b010, 16, "R9 sequential page read");
        b_stop();

        // R8: current-pointer read with unrelated block bits continues at 0x280
        read_seq(3'b101, 3'b111, 2, "R8 current read continues");
        b_stop();

        // R9: sequential read across the top of the array
        set_ptr(3'b101, 32'h7FE);
        read_seq(3'b101, 3'b000, 3, "R9 wrap 0x7FF to 0x000");
        b_stop();

        // R2: mismatched header is ignored, nothing written
        wr0 = wr_count;
        b_start();
        send_byte(hdr(3'b111, 3'b000, 1'b0), 1'b0, a);
        chk(!a, "R2 mismatch no ack", a, 0);
        send_byte(8'h10, 1'b0, a);
        chk(!a, "R2 ignored byte no ack", a, 0);
        send_byte(8'h55, 1'b0, a);
        b_stop();
        chk(wr_count == wr0, "R2 mismatch no write", wr_count - wr0, 0);

        // R2: middle strap bit compared inverted
        strap = 3'b010;
        tick(20);
        b_start();
        send_byte({1'b1, 3'b010, 3'b000, 1'b0}, 1'b0, a);
        chk(!a, "R2 non-inverted select rejected", a, 0);
        b_stop();
        write_bytes(3'b010, 32'h001, 1, 8'h99);
        set_ptr(3'b010, 32'h001);
        read_seq(3'b010, 3'b000, 1, "R2 inverted select read back");
        b_stop();

        // R1 R11: repeated start inside the word address byte
        keep = model_ptr;
        b_start();
        send_byte(hdr(3'b010, 3'b011, 1'b0), 1'b1, a);
        chk(a, "R1 header ack", a, 1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        chk(model_ptr == keep, "R11 pointer kept", model_ptr, keep);
        read_seq(3'b010, 3'b000, 1, "R11 read after aborted address");
        b_stop();

        // R1 R11: stop inside a data byte writes nothing
        wr0 = wr_count;
        set_ptr(3'b010, 32'h345);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        b_stop();
        chk(wr_count == wr0, "R11 partial byte not written", wr_count - wr0, 0);
        read_seq(3'b010, 3'b000, 1, "R1 read after stop abort");
        b_stop();
        d = mem[11'h345];
        chk(d == model_mem[32'h345], "R11 location intact", d, model_mem[32'h345]);

        tick(20);
        finish_run();
    end
endmodule